// File: doc/BRIEF.md
# Signature Fingerprint Compactor

This block folds a bus of monitored internal nodes into a 16-bit fingerprint once per clock. A row of signature cells hashes the nodes across space. Each cell takes its own node and XORs it with the value arriving from its upstream neighbour, then hands the result downstream on the next edge. The cell at the far end of the row feeds one bit per cycle into a Galois LFSR, which hashes that serial stream across time.

A test run works as follows. A start pulse wipes the cells and seeds the LFSR. Capture then runs for as many cycles as the test needs. A flush request ends capture and begins a cool-down of exactly one cycle per cell. During cool-down the node bus is replaced by zeros, so every captured bit still in the row reaches the LFSR. One cycle after cool-down ends, a done pulse is raised and the fingerprint is compared with a golden value. The outcome is held until the next start.

A separate enable freezes the whole block, so it costs no switching when no test is running. Because the fingerprint is a linear hash, one wrong captured bit anywhere in a run changes it.

Top module: `sig_compactor`

## Requirements
- R1: After reset, `done_o` and `mismatch_o` are 0 and `sig_o` holds the seed 16'h0001.
- R2: A cycle with `start_i` high, whether or not the block is enabled, clears every cell to 0, loads `sig_o` with 16'h0001, and clears `done_o` and `mismatch_o` on the next cycle.
- R3: On each shifting cycle, cell 0 takes `mon_i[0]`, and cell i (i ≥ 1) takes `mon_i[i]` XOR the previous value of cell i-1. The previous value of cell N-1 is the serial bit handed to the LFSR.
- R4: On each shifting cycle, the LFSR state s becomes `{s[14:0],0}` XOR (f ? 16'h6801 : 0), where f = s[15] XOR the serial bit. This is the polynomial x^16+x^14+x^13+x^11+1.
- R5: The cycle in which `flush_i` is accepted during capture does not shift. Exactly N shifting cool-down cycles follow, and in them `mon_i` is ignored and treated as all zeros.
- R6: `done_o` is high for exactly one cycle, namely the cycle after the last cool-down shift.
- R7: In the cycle where `done_o` is high, `mismatch_o` is 1 exactly when `sig_o` differs from `golden_i`. It keeps that value until the next start.
- R8: While `sig_en_i` is low, the cells, the LFSR and the run sequence all hold their values. Captured nodes in those cycles are ignored.
- R9: A run whose captured nodes differ from the reference run in exactly one bit of one cycle ends with `mismatch_o` = 1 when `golden_i` holds the reference fingerprint.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sig_en_i | input | 1 | Enable for the cells, the LFSR and the sequencer |
| start_i | input | 1 | Clear and seed, then begin capture |
| flush_i | input | 1 | End capture and begin cool-down |
| mon_i | input | N | Monitored node bus; bit i feeds cell i |
| golden_i | input | 16 | Reference fingerprint |
| sig_o | output | 16 | Current LFSR fingerprint |
| done_o | output | 1 | One-cycle pulse when the fingerprint is final |
| mismatch_o | output | 1 | Fingerprint differs from the reference; held until the next start |

## Verification
Four node patterns are captured: all zeros, a walking one, an arithmetic counter and a multiplicative hash. All zeros exposes the effect of the seed alone. The walking one checks that each cell lands in the right place in the row. The counter and the hash check the XOR chaining and the LFSR feedback under dense input. Each pattern is run once against a clean reference and again with one bit flipped at every cell position in turn, which confirms that a single fault always flips the comparison. One run inserts disabled cycles that carry foreign node values. Every cool-down drives all-ones on the node bus. Together these show that both the enable gaps and the flush zeroing leave the fingerprint untouched.

// File: rtl/sigc_pkg.sv
package sigc_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_CAPT  = 2'd1,
        ST_FLUSH = 2'd2
    } run_st_e;

    typedef struct packed {
        logic done;
        logic mis;
    } flag_regs_t;

endpackage

// File: rtl/sigc_chain.sv
module sigc_chain #(
    parameter int N = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         shift,
    input  logic         zero_in,
    input  logic [N-1:0] mon_i,
    output logic         tail_o
);

    logic [N-1:0] din;
    logic [N-1:0] step;
    logic [N-1:0] cell_d, cell_q;

    assign din = zero_in ? '0 : mon_i;

    // Each cell folds its node into the value arriving from upstream.
    assign step[0] = din[0];
    generate
        for (genvar i = 1; i < N; i++) begin : g_cell
            assign step[i] = din[i] ^ cell_q[i-1];
        end
    endgenerate

    always_comb begin
        cell_d = cell_q;
        if (clr)
            cell_d = '0;
        else if (shift)
            cell_d = step;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cell_q <= '0;
        else        cell_q <= cell_d;
    end

    assign tail_o = cell_q[N-1];

endmodule

// File: rtl/sigc_lfsr.sv
module sigc_lfsr #(
    parameter int           W    = 16,
    parameter logic [W-1:0] POLY = 16'h6801,
    parameter logic [W-1:0] SEED = 16'h0001
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         shift,
    input  logic         ser_i,
    output logic [W-1:0] state_o,
    output logic [W-1:0] next_o
);

    logic [W-1:0] s_d, s_q;
    logic         fb;

    assign fb = s_q[W-1] ^ ser_i;

    always_comb begin
        s_d = s_q;
        if (clr)
            s_d = SEED;
        else if (shift)
            s_d = {s_q[W-2:0], 1'b0} ^ (fb ? POLY : '0);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= SEED;
        else        s_q <= s_d;
    end

    assign state_o = s_q;
    assign next_o  = s_d;

endmodule

// File: rtl/sigc_ctrl.sv
module sigc_ctrl
    import sigc_pkg::*;
#(
    parameter int N = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en_i,
    input  logic start_i,
    input  logic flush_i,
    output logic shift_o,
    output logic zero_o,
    output logic last_o
);

    localparam int CNT_W = (N > 1) ? $clog2(N) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(N - 1);

    typedef struct packed {
        run_st_e          st;
        logic [CNT_W-1:0] cnt;
    } ctrl_regs_t;

    ctrl_regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (start_i) begin
            r_d.st  = ST_CAPT;
            r_d.cnt = '0;
        end else if (en_i) begin
            unique case (r_q.st)
                ST_CAPT: begin
                    if (flush_i) begin
                        r_d.st  = ST_FLUSH;
                        r_d.cnt = '0;
                    end
                end
                ST_FLUSH: begin
                    if (r_q.cnt == CNT_LAST) r_d.st = ST_IDLE;
                    else                     r_d.cnt = r_q.cnt + 1'b1;
                end
                default: r_d.st = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.st  <= ST_IDLE;
            r_q.cnt <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign shift_o = !start_i && en_i &&
                     ((r_q.st == ST_CAPT && !flush_i) || r_q.st == ST_FLUSH);
    assign zero_o  = (r_q.st == ST_FLUSH);
    assign last_o  = !start_i && en_i && r_q.st == ST_FLUSH && r_q.cnt == CNT_LAST;

endmodule

// File: rtl/sig_compactor.sv
module sig_compactor
    import sigc_pkg::*;
#(
    parameter int N = 8,
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         sig_en_i,
    input  logic         start_i,
    input  logic         flush_i,
    input  logic [N-1:0] mon_i,
    input  logic [W-1:0] golden_i,
    output logic [W-1:0] sig_o,
    output logic         done_o,
    output logic         mismatch_o
);

    logic         shift, zero_in, last, tail;
    logic [W-1:0] lfsr_next;
    flag_regs_t   f_d, f_q;

    sigc_ctrl #(.N(N)) u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .en_i    (sig_en_i),
        .start_i (start_i),
        .flush_i (flush_i),
        .shift_o (shift),
        .zero_o  (zero_in),
        .last_o  (last)
    );

    sigc_chain #(.N(N)) u_chain (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (start_i),
        .shift   (shift),
        .zero_in (zero_in),
        .mon_i   (mon_i),
        .tail_o  (tail)
    );

    sigc_lfsr #(.W(W)) u_lfsr (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (start_i),
        .shift   (shift),
        .ser_i   (tail),
        .state_o (sig_o),
        .next_o  (lfsr_next)
    );

    always_comb begin
        f_d      = f_q;
        f_d.done = last;
        if (start_i)
            f_d.mis = 1'b0;
        else if (last)
            f_d.mis = (lfsr_next != golden_i);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) f_q <= '0;
        else        f_q <= f_d;
    end

    assign done_o     = f_q.done;
    assign mismatch_o = f_q.mis;

endmodule

// File: rtl/sigc_chk.sv
module sigc_chk #(
    parameter int W = 16
) (
    input logic         clk,
    input logic         rst_n,
    input logic         start_i,
    input logic         sig_en_i,
    input logic [W-1:0] sig_o,
    input logic         done_o,
    input logic         mismatch_o
);

    AST_START_SEEDS: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> (sig_o == W'(1) && !done_o && !mismatch_o)); // R2

    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o); // R6

    AST_VERDICT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !start_i |=> (done_o || $stable(mismatch_o))); // R7

    AST_FROZEN_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (!sig_en_i && !start_i) |=> ($stable(sig_o) && !done_o)); // R8

endmodule

bind sig_compactor sigc_chk #(.W(W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start_i),
    .sig_en_i   (sig_en_i),
    .sig_o      (sig_o),
    .done_o     (done_o),
    .mismatch_o (mismatch_o)
);

// File: tb/tb_sig_compactor.sv
module tb_sig_compactor;

    localparam int CLK_PERIOD = 10;
    localparam int N   = 8;
    localparam int W   = 16;
    localparam int LEN = 20;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         sig_en_i = 1'b0;
    logic         start_i = 1'b0;
    logic         flush_i = 1'b0;
    logic [N-1:0] mon_i = '0;
    logic [W-1:0] golden_i = '0;
    logic [W-1:0] sig_o;
    logic         done_o;
    logic         mismatch_o;

    int n_run = 0;
    int n_fail = 0;
    bit finished = 0;

    logic [N-1:0] m_cell;
    logic [W-1:0] m_lfsr;

    always #(CLK_PERIOD/2) clk = ~clk;

    sig_compactor #(.N(N), .W(W)) dut (
        .clk(clk), .rst_n(rst_n), .sig_en_i(sig_en_i), .start_i(start_i),
        .flush_i(flush_i), .mon_i(mon_i), .golden_i(golden_i),
        .sig_o(sig_o), .done_o(done_o), .mismatch_o(mismatch_o)
    );

    task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [N-1:0] pattern(input int p, input int t);
        logic [31:0] h;
        case (p)
            0: return '0;
            1: return N'(1) << (t % N);
            2: return N'(t * 37 + 5);
            default: begin
                h = (t + 1) * 32'h9E3779B1;
                return N'(h >> 13);
            end
        endcase
    endfunction

    // Reference shift from R3 and R4.
    task automatic model_shift(input logic [N-1:0] v);
        logic       fb;
        logic [N-1:0] nc;
        fb = m_lfsr[W-1] ^ m_cell[N-1];
        m_lfsr = {m_lfsr[W-2:0], 1'b0} ^ (fb ? 16'h6801 : 16'h0000);
        nc[0] = v[0];
        for (int i = 1; i < N; i++) nc[i] = v[i] ^ m_cell[i-1];
        m_cell = nc;
    endtask

    task automatic run(input int pat, input int err_pos, input int err_cyc,
                       input logic [W-1:0] gold, input bit gap,
                       output logic [W-1:0] result);
        logic [N-1:0] v;
        logic [W-1:0] held;
        logic         verdict;
        golden_i = gold;
        start_i  = 1'b1;
        @(negedge clk);
        start_i  = 1'b0;
        m_cell = '0;
        m_lfsr = 16'h0001;
        check("R2 seed", sig_o, 16'h0001);
        check("R2 mismatch cleared", W'(mismatch_o), '0);
        for (int t = 0; t < LEN; t++) begin
            v = pattern(pat, t);
            if (t == err_cyc && err_pos >= 0) v[err_pos] = ~v[err_pos];
            if (gap && t == 5) begin
                held = sig_o;
                sig_en_i = 1'b0;
                for (int g = 0; g < 3; g++) begin
                    mon_i = ~v ^ N'(g);
                    @(negedge clk);
                    check("R8 frozen sig", sig_o, held);
                end
                sig_en_i = 1'b1;
            end
            mon_i = v;
            @(negedge clk);
            model_shift(v);
        end
        flush_i = 1'b1;
        mon_i   = N'(8'hA5);
        @(negedge clk);
        flush_i = 1'b0;
        for (int k = 0; k < N; k++) begin
            mon_i = '1;
            @(negedge clk);
            model_shift('0);
            if (k < N-1) check("R6 no early done", W'(done_o), '0);
        end
        verdict = (m_lfsr != gold);
        check("R6 done raised", W'(done_o), W'(1));
        check("R3 R4 R5 fingerprint", sig_o, m_lfsr);
        check("R7 verdict", W'(mismatch_o), W'(verdict));
        @(negedge clk);
        check("R6 done single", W'(done_o), '0);
        check("R7 verdict held", W'(mismatch_o), W'(verdict));
        result = m_lfsr;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        logic [W-1:0] g, r;
        repeat (3) @(negedge clk);
        check("R1 reset done", W'(done_o), '0);
        check("R1 reset mismatch", W'(mismatch_o), '0);
        check("R1 reset seed", sig_o, 16'h0001);
        rst_n = 1'b1;
        sig_en_i = 1'b1;
        @(negedge clk);
        for (int p = 0; p < 4; p++) begin
            run(p, -1, 0, 16'h0000, 0, g);
            run(p, -1, 0, g, 0, r);
            check("R7 clean run matches", W'(mismatch_o), '0);
            for (int pos = 0; pos < N; pos++) begin
                run(p, pos, (pos * 3 + p) % LEN, g, 0, r);
                check("R9 single flip detected", W'(mismatch_o), W'(1));
            end
            run(p, -1, 0, g, 1, r);
            check("R8 gap run matches clean", W'(mismatch_o), '0);
        end
        finished = 1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule